// File: doc/BRIEF.md
# Redundant clock failover controller

This block decides which of two redundant input clocks feeds a downstream clock path. A free-running reference clock, faster than either monitored clock, samples both inputs at all times. Each input has its own detector. A detector brings its input into the reference domain and counts reference cycles since that input last changed level. If the input stays high, or stays low, for longer than one expected period plus a small margin, the detector reports it as dead.

A dead input sets a bad flag for that input. The flag stays set until an alarm-clear pulse or a reset clears it. When the input that is currently selected goes bad, the selection moves to the other input, but only if the other input's flag is clear. A manual override makes the selection follow a select pin and disables automatic failover. All outputs are registered in the reference domain. The block does not contain the clock multiplexer itself; the selection output is meant to steer one.

Top module: `clksw_ctrl`

## Requirements
- R1: The two inputs are watched at the same time by independent detectors. A failure on one input sets only that input's flag (bad_flag bit i belongs to src_clk[i]), and inputs that stop together get their flags in the same cycle.
- R2: An input is reported dead once more than PERIOD_CYC+MARGIN_CYC reference cycles pass without a rising or falling edge on it. An input whose level changes every PERIOD_CYC+3 reference cycles is never flagged. One that changes every PERIOD_CYC+4 cycles is flagged.
- R3: With the default two synchronizer stages, the flag of a stopped input rises at the (PERIOD_CYC+MARGIN_CYC+4)th reference rising edge after the first edge that samples the input's last change, and not earlier.
- R4: A bad flag stays high after its input starts toggling again, until alarm_clr or rst.
- R5: sel_src reports the active input (0 means src_clk[0], 1 means src_clk[1]). With man_ovr and alarm_clr low, if the selected input's flag is set and the other flag is clear, sel_src changes to the other input one reference cycle after the flag is seen.
- R6: A failure on the input that is not selected sets its flag but leaves sel_src unchanged.
- R7: With both flags set and man_ovr low, sel_src holds its value, and changes of pri_sel have no effect on it.
- R8: An alarm_clr pulse clears both flags and loads sel_src from pri_sel one cycle later. The clear wins over a failure in the same cycle. If the input is still dead, its flag sets again one cycle after the clear.
- R9: While man_ovr is high, sel_src takes the value pri_sel had one cycle earlier and no automatic switch happens. The flags keep updating.
- R10: Synchronous active-high rst clears both flags and loads sel_src from pri_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, faster than both monitored clocks |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | 2 | The two monitored input clocks, asynchronous to clk |
| pri_sel | input | 1 | Preferred input: 0 for src_clk[0], 1 for src_clk[1] |
| man_ovr | input | 1 | High: selection follows pri_sel and automatic failover is off |
| alarm_clr | input | 1 | Synchronous pulse that clears both bad flags and reloads the selection |
| bad_flag | output | 2 | Sticky failure flags, bit i for src_clk[i] |
| sel_src | output | 1 | Currently selected input |

## Verification
Control inputs (alarm_clr, man_ovr, pri_sel, rst) are registered once, so their effect on bad_flag and sel_src is due one reference cycle after the edge that samples them. A failover decision shows one cycle after the flag that causes it. A stopped input's flag is due a fixed number of cycles after the last level change, set by the synchronizer depth, the edge register and the counter limit. The bench records the cycle of every level change it drives and, from that, computes the exact cycle in which each flag and selection change is due. It queues the expected values with those due cycles and checks the cycle before a flag is due as well as the cycle it rises. Inputs are driven just after a rising edge and outputs are compared at the falling edge, so each comparison lands on a settled value.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // number of redundant inputs handled by the controller
  localparam int NUM_SRC = 2;

  // how the selection register is loaded in a given cycle
  typedef enum logic [1:0] {
    MODE_FOLLOW_PIN = 2'd0,
    MODE_FAILOVER   = 2'd1,
    MODE_HOLD       = 2'd2
  } sel_mode_e;

  // counter width that can hold max_val
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
// multi-flop synchronizer into the reference domain
module clksw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];

endmodule

// File: rtl/clksw_activity_mon.sv
// watches one input: any level change restarts a saturating idle counter
module clksw_activity_mon import clksw_pkg::*; #(
  parameter int PERIOD_CYC  = 8,
  parameter int MARGIN_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_i,
  output logic dead_o
);

  localparam int LIMIT = PERIOD_CYC + MARGIN_CYC;
  localparam int SAT   = LIMIT + 1;
  localparam int CNT_W = cnt_width(SAT);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic             synced;
  logic             prev_q;
  logic             toggled;
  logic [CNT_W-1:0] idle_q;

  clksw_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (mon_i),
    .q_o (synced)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  // rising and falling edges both count as activity
  assign toggled = synced ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst)                 idle_q <= '0;
    else if (toggled)        idle_q <= '0;
    else if (idle_q != SAT_V) idle_q <= idle_q + ONE_V;
  end

  // saturated count means more than LIMIT idle cycles
  assign dead_o = (idle_q == SAT_V);

endmodule

// File: rtl/clksw_flag_bank.sv
// one sticky failure flag per input
module clksw_flag_bank import clksw_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               alarm_clr,
  input  logic [NUM_SRC-1:0] dead_i,
  output logic [NUM_SRC-1:0] bad_o
);

  logic [NUM_SRC-1:0] bad_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || alarm_clr) bad_q[g] <= 1'b0;
      else if (dead_i[g])   bad_q[g] <= 1'b1;
    end
  end

  assign bad_o = bad_q;

endmodule

// File: rtl/clksw_selector.sv
// selection register with failover, manual follow and hold
module clksw_selector import clksw_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               pri_sel,
  input  logic               man_ovr,
  input  logic               alarm_clr,
  input  logic [NUM_SRC-1:0] bad_i,
  output logic               sel_o
);

  sel_mode_e mode;
  logic      sel_q;
  logic      sel_d;
  logic      cur_bad;
  logic      alt_bad;

  assign cur_bad = bad_i[sel_q];
  assign alt_bad = bad_i[~sel_q];

  always_comb begin
    if (alarm_clr || man_ovr)   mode = MODE_FOLLOW_PIN;
    else if (cur_bad && !alt_bad) mode = MODE_FAILOVER;
    else                        mode = MODE_HOLD;

    case (mode)
      MODE_FOLLOW_PIN: sel_d = pri_sel;
      MODE_FAILOVER:   sel_d = ~sel_q;
      default:         sel_d = sel_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= pri_sel;
    else     sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/clksw_ctrl.sv
// top: two activity monitors, sticky flags, selection register
module clksw_ctrl import clksw_pkg::*; #(
  parameter int PERIOD_CYC  = 8,
  parameter int MARGIN_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               pri_sel,
  input  logic               man_ovr,
  input  logic               alarm_clr,
  output logic [NUM_SRC-1:0] bad_flag,
  output logic               sel_src
);

  logic [NUM_SRC-1:0] dead;
  logic [NUM_SRC-1:0] bad;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mon
    clksw_activity_mon #(
      .PERIOD_CYC  (PERIOD_CYC),
      .MARGIN_CYC  (MARGIN_CYC),
      .SYNC_STAGES (SYNC_STAGES)
    ) mon_i (
      .clk    (clk),
      .rst    (rst),
      .mon_i  (src_clk[g]),
      .dead_o (dead[g])
    );
  end

  clksw_flag_bank flags_i (
    .clk       (clk),
    .rst       (rst),
    .alarm_clr (alarm_clr),
    .dead_i    (dead),
    .bad_o     (bad)
  );

  clksw_selector sel_i (
    .clk       (clk),
    .rst       (rst),
    .pri_sel   (pri_sel),
    .man_ovr   (man_ovr),
    .alarm_clr (alarm_clr),
    .bad_i     (bad),
    .sel_o     (sel_src)
  );

  assign bad_flag = bad;

endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pri_sel,
  input logic       man_ovr,
  input logic       alarm_clr,
  input logic [1:0] bad_flag,
  input logic       sel_src
);

  for (genvar g = 0; g < 2; g++) begin : g_sticky
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (bad_flag[g] && !alarm_clr) |=> bad_flag[g]);
  end

  assert_clear_reload_R8: assert property (@(posedge clk) disable iff (rst)
    alarm_clr |=> (bad_flag == 2'b00) && (sel_src == $past(pri_sel)));

  assert_override_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (man_ovr && !alarm_clr) |=> (sel_src == $past(pri_sel)));

  assert_failover_R5: assert property (@(posedge clk) disable iff (rst)
    (!man_ovr && !alarm_clr && bad_flag[sel_src] && !bad_flag[~sel_src])
      |=> (sel_src != $past(sel_src)));

  assert_keep_selection_R6: assert property (@(posedge clk) disable iff (rst)
    (!man_ovr && !alarm_clr && !bad_flag[sel_src]) |=> $stable(sel_src));

  assert_both_bad_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!man_ovr && !alarm_clr && (bad_flag == 2'b11)) |=> $stable(sel_src));

endmodule

bind clksw_ctrl clksw_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .pri_sel   (pri_sel),
  .man_ovr   (man_ovr),
  .alarm_clr (alarm_clr),
  .bad_flag  (bad_flag),
  .sel_src   (sel_src)
);

// File: tb/clksw_ctrl_tb_top.sv
module clksw_ctrl_tb_top;

  localparam int PERIOD = 8;
  localparam int MARGIN = 2;
  localparam int LIMIT  = PERIOD + MARGIN;
  localparam int LAT    = LIMIT + 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src = 2'b00;
  logic       pri_sel = 1'b0;
  logic       man_ovr = 1'b0;
  logic       alarm_clr = 1'b0;
  logic [1:0] bad_flag;
  logic       sel_src;

  always #2 clk = ~clk;  // 250 MHz

  clksw_ctrl #(.PERIOD_CYC(PERIOD), .MARGIN_CYC(MARGIN), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst (rst), .src_clk (src), .pri_sel (pri_sel),
    .man_ovr (man_ovr), .alarm_clr (alarm_clr), .bad_flag (bad_flag), .sel_src (sel_src)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitored clock generators, updated on falling edges
  int half[2]     = '{4, 4};
  bit run[2]      = '{1'b1, 1'b1};
  int ph[2]       = '{0, 0};
  int last_tog[2] = '{0, 0};

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (run[i]) begin
        if (ph[i] >= half[i] - 1) begin
          src[i] = ~src[i];
          ph[i] = 0;
          last_tog[i] = cyc;
        end else begin
          ph[i] = ph[i] + 1;
        end
      end
    end
  end

  // scoreboard: kind 0 = bad_flag[0], 1 = bad_flag[1], 2 = sel_src
  typedef struct {
    int    due;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic push_exp(input int due, input int kind, input int val, input string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin : monitor
    int k;
    int act;
    k = 0;
    while (k < q.size()) begin
      if (q[k].due <= cyc) begin
        act = (q[k].kind == 2) ? int'(sel_src) : int'(bad_flag[q[k].kind]);
        n_chk++;
        if (act != q[k].val || q[k].due != cyc) begin
          n_bad++;
          $display("FAIL %s kind=%0d cyc=%0d due=%0d actual=%0d expected=%0d",
                   q[k].tag, q[k].kind, cyc, q[k].due, act, q[k].val);
        end
        q.delete(k);
      end else begin
        k++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_all(input int due, input int b0, input int b1, input int s, input string tag);
    push_exp(due, 0, b0, tag);
    push_exp(due, 1, b1, tag);
    push_exp(due, 2, s, tag);
  endtask

  task automatic pulse_clear(input logic sel, input string tag);
    pri_sel = sel;
    alarm_clr = 1'b1;
    exp_all(cyc + 1, 0, 0, int'(sel), tag);
    step(1);
    alarm_clr = 1'b0;
  endtask

  task automatic restart_both();
    half[0] = 4; half[1] = 4;
    ph[0] = 0; ph[1] = 0;
    run[0] = 1'b1; run[1] = 1'b1;
  endtask

  int d0, d1;

  initial begin
    // R10: reset state
    step(3);
    exp_all(cyc, 0, 0, 0, "R10 reset");
    step(1);
    rst = 1'b0;
    step(20);
    exp_all(cyc, 0, 0, 0, "R2 running inputs unflagged");

    // R2 boundary: level change every PERIOD+3 cycles is tolerated
    half[0] = PERIOD + 3;
    step(40);
    exp_all(cyc, 0, 0, 0, "R2 gap PERIOD+3 no flag");
    step(40);
    exp_all(cyc, 0, 0, 0, "R2 gap PERIOD+3 still no flag");
    // every PERIOD+4 cycles is a failure, selected input -> failover
    half[0] = PERIOD + 4;
    step(60);
    exp_all(cyc, 1, 0, 1, "R2 gap PERIOD+4 flagged, R5 failover");

    // back to normal and clear
    half[0] = 4;
    step(20);
    pulse_clear(1'b0, "R8 clear reloads from pin");
    step(20);
    exp_all(cyc, 0, 0, 0, "R8 steady after clear");

    // R3 exact latency on selected input 0
    run[0] = 1'b0;
    d0 = last_tog[0] + LAT;
    push_exp(d0 - 1, 0, 0, "R3 flag not early");
    push_exp(d0, 0, 1, "R3 flag on time");
    push_exp(d0, 2, 0, "R5 selection before failover");
    push_exp(d0 + 1, 2, 1, "R5 failover one cycle after flag");
    push_exp(d0 + 1, 1, 0, "R1 other flag untouched");
    step(d0 + 5 - cyc);

    // R4 sticky after restart
    ph[0] = 0; run[0] = 1'b1;
    step(60);
    exp_all(cyc, 1, 0, 1, "R4 flag sticky after restart");

    // R6 failure of non-selected input
    pulse_clear(1'b0, "R8 clear before R6");
    step(20);
    run[1] = 1'b0;
    d1 = last_tog[1] + LAT;
    push_exp(d1 - 1, 1, 0, "R3 input1 flag not early");
    push_exp(d1, 1, 1, "R1 input1 flagged alone");
    push_exp(d1 + 1, 2, 0, "R6 selection kept");
    exp_all(d1 + 5, 0, 1, 0, "R6 selection kept later");
    step(d1 + 6 - cyc);

    // R8 clear wins, dead input re-flags, then failover
    pri_sel = 1'b1;
    alarm_clr = 1'b1;
    exp_all(cyc + 1, 0, 0, 1, "R8 clear with dead input");
    push_exp(cyc + 2, 1, 1, "R8 flag sets again after clear");
    push_exp(cyc + 3, 2, 0, "R5 failover after re-flag");
    step(1);
    alarm_clr = 1'b0;
    step(5);

    // R9 manual override
    ph[1] = 0; run[1] = 1'b1;
    step(30);
    pulse_clear(1'b0, "R8 clear before R9");
    step(10);
    man_ovr = 1'b1;
    pri_sel = 1'b1;
    push_exp(cyc + 1, 2, 1, "R9 override follows pin");
    step(10);
    run[1] = 1'b0;
    d1 = last_tog[1] + LAT;
    push_exp(d1, 1, 1, "R9 flag updates under override");
    push_exp(d1 + 1, 2, 1, "R9 no failover under override");
    push_exp(d1 + 10, 2, 1, "R9 no failover later");
    step(d1 + 11 - cyc);
    pri_sel = 1'b0;
    push_exp(cyc + 1, 2, 0, "R9 override follows pin low");
    step(5);
    man_ovr = 1'b0;
    step(5);

    // R7 / R1: both inputs stop together
    restart_both();
    step(30);
    pulse_clear(1'b0, "R8 clear before R7");
    step(20);
    run[0] = 1'b0; run[1] = 1'b0;
    d0 = last_tog[0] + LAT;
    d1 = last_tog[1] + LAT;
    push_exp(d0, 0, 1, "R1 input0 flagged together");
    push_exp(d1, 1, 1, "R1 input1 flagged together");
    d0 = (d0 > d1) ? d0 : d1;
    push_exp(d0 + 1, 2, 0, "R7 hold with both bad");
    push_exp(d0 + 10, 2, 0, "R7 hold with both bad later");
    step(d0 + 11 - cyc);
    pri_sel = 1'b1;
    push_exp(cyc + 1, 2, 0, "R7 pin ignored with both bad");
    push_exp(cyc + 5, 2, 0, "R7 pin still ignored");
    step(6);

    // R10 reset loads selection from pin
    rst = 1'b1;
    exp_all(cyc + 1, 0, 0, 1, "R10 reset with pin high");
    step(3);
    rst = 1'b0;
    step(3);

    if (q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL all pending expectations consumed actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(4 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule